// File: doc/BRIEF.md
# Eight-Mode Shift/Complement Register

This block is a parameterised register of `L` bits whose contents move to a new value chosen by a three-bit mode code. The register changes only when its enable is high. Every flip-flop has its own eight-way multiplexer. The eight choices are:

- keep the current value
- invert every bit
- logical shift by one place, either direction
- rotate by one place, either direction
- arithmetic shift by one place, either direction

Rotation takes each bit's neighbour index modulo `L`. The arithmetic right shift copies the top bit back into itself, so the sign is kept.

A separate load strobe copies a parallel input word into the register. The load is taken only with the enable high, and it wins over the mode code. A registered shift-out flag holds the bit that the last one-place shift pushed off the end. In every other mode the flag is 0. The reset is synchronous and active high, and it clears both the register and the flag.

A datapath controller uses the block as a working register. It steps the register one microoperation at a time. Each operation takes one clock edge.

Top module: `shreg8m`

## Requirements
- R1: When `rst` is high at a rising edge, `q` and `shout` become 0 on that edge, whatever the other inputs are.
- R2: When `en` is low, `q` and `shout` keep their values, including when `load` is high.
- R3: When `en` and `load` are both high, `q` takes `din` and `shout` becomes 0, for any value of `sel`.
- R4: When `en` is high, `load` is low and `sel` is 0, `q` keeps its value and `shout` becomes 0.
- R5: With `sel` = 1 (same enable and load conditions), every bit of `q` is inverted and `shout` becomes 0.
- R6: With `sel` = 2, the new `q[i]` is the old `q[i-1]` and the new `q[0]` is 0. `shout` takes the old `q[L-1]`.
- R7: With `sel` = 3, the new `q[i]` is the old `q[i+1]` and the new `q[L-1]` is 0. `shout` takes the old `q[0]`.
- R8: With `sel` = 4, the new `q[i]` is the old `q[(L+i-1) mod L]`, which is a rotate left. `shout` becomes 0.
- R9: With `sel` = 5, the new `q[i]` is the old `q[(L+i+1) mod L]`, which is a rotate right. `shout` becomes 0.
- R10: With `sel` = 6, the block behaves exactly as with `sel` = 2. A 0 enters bit 0, and the old `q[L-1]` goes to `shout`.
- R11: With `sel` = 7, the new `q[i]` is the old `q[i+1]` for i < L-1, and `q[L-1]` keeps its value. `shout` takes the old `q[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable |
| load | input | 1 | Parallel load strobe; wins over `sel` when `en` is high |
| sel | input | 3 | Mode code 0..7 |
| din | input | L | Parallel load data |
| q | output | L | Register contents |
| shout | output | 1 | Bit lost by the last one-place shift; 0 after any other update |

## Verification
The assertions check the following on every cycle:

- the register and flag are held while the enable is low
- a load copies `din` exactly
- inversion is exact
- both rotations keep the population count
- the arithmetic right shift keeps the top bit
- the flag is 0 after every update that is not a shift

The exact bit movement of each shift, the fill values at the ends, the bit captured in the flag, and load winning over a shift code can only be shown by the bench's vector sequence. The bench checks these against hand-computed words. Reset in the middle of a run, and a load attempt while the enable is low, are shown by directed scenarios.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [2:0] {
    M_KEEP = 3'd0,
    M_INV  = 3'd1,
    M_SHL  = 3'd2,
    M_SHR  = 3'd3,
    M_ROL  = 3'd4,
    M_ROR  = 3'd5,
    M_ASL  = 3'd6,
    M_ASR  = 3'd7
  } mode_e;
endpackage

// File: rtl/shreg_bit_mux.sv
module shreg_bit_mux
  import shreg_pkg::*;
#(
  parameter bit IS_LSB = 1'b0,
  parameter bit IS_MSB = 1'b0
) (
  input  mode_e mode,
  input  logic  own,
  input  logic  lower,   // bit index - 1, wrapped
  input  logic  upper,   // bit index + 1, wrapped
  output logic  nxt
);
  always_comb begin
    unique case (mode)
      M_KEEP:        nxt = own;
      M_INV:         nxt = ~own;
      M_SHL, M_ASL:  nxt = IS_LSB ? 1'b0 : lower;
      M_SHR:         nxt = IS_MSB ? 1'b0 : upper;
      M_ROL:         nxt = lower;
      M_ROR:         nxt = upper;
      M_ASR:         nxt = IS_MSB ? own : upper;
      default:       nxt = own;
    endcase
  end
endmodule

// File: rtl/shreg_shout_sel.sv
module shreg_shout_sel
  import shreg_pkg::*;
(
  input  mode_e mode,
  input  logic  load,
  input  logic  top_bit,
  input  logic  low_bit,
  output logic  lost
);
  always_comb begin
    if (load) begin
      lost = 1'b0;
    end else begin
      unique case (mode)
        M_SHL, M_ASL: lost = top_bit;
        M_SHR, M_ASR: lost = low_bit;
        default:      lost = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/shreg8m.sv
module shreg8m
  import shreg_pkg::*;
#(
  parameter int L = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [2:0]   sel,
  input  logic [L-1:0] din,
  output logic [L-1:0] q,
  output logic         shout
);
  localparam int MSB = L - 1;

  mode_e          mode;
  logic [L-1:0]   shifted;
  logic [L-1:0]   next_q;
  logic           lost;

  assign mode = mode_e'(sel);

  for (genvar i = 0; i < L; i++) begin : g_bit
    localparam int LO = (i == 0)   ? MSB : i - 1;
    localparam int HI = (i == MSB) ? 0   : i + 1;
    shreg_bit_mux #(
      .IS_LSB(i == 0),
      .IS_MSB(i == MSB)
    ) u_mux (
      .mode (mode),
      .own  (q[i]),
      .lower(q[LO]),
      .upper(q[HI]),
      .nxt  (shifted[i])
    );
  end

  shreg_shout_sel u_shout (
    .mode   (mode),
    .load   (load),
    .top_bit(q[MSB]),
    .low_bit(q[0]),
    .lost   (lost)
  );

  assign next_q = load ? din : shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      shout <= 1'b0;
    end else if (en) begin
      q     <= next_q;
      shout <= lost;
    end
  end

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (q == '0 && shout == 1'b0));

  // R2
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q) && $stable(shout)));

  // R3
  p_load_copies_r3: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> (q == $past(din) && shout == 1'b0));

  // R5
  p_invert_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !load && sel == 3'd1) |=> (q == ~$past(q)));

  // R8, R9: rotations neither gain nor lose ones
  p_rotate_count_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !load && (sel == 3'd4 || sel == 3'd5))
      |=> ($countones(q) == $countones($past(q))));

  // R11
  p_sign_kept_r11: assert property (@(posedge clk) disable iff (rst)
    (en && !load && sel == 3'd7) |=> (q[MSB] == $past(q[MSB])));

  // R4, R5, R8, R9
  p_flag_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !load && (sel == 3'd0 || sel == 3'd1 || sel == 3'd4 || sel == 3'd5))
      |=> (shout == 1'b0));
endmodule

// File: tb/shreg8m_tb.sv
module shreg8m_tb;
  localparam int L = 8;
  // vector: {load, sel[2:0], din[7:0], exp_q[7:0], exp_shout}
  localparam int NV = 19;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'hA5, 8'hA5, 1'b0},  // R3 load
    {1'b0, 3'd0, 8'h00, 8'hA5, 1'b0},  // R4 keep
    {1'b0, 3'd1, 8'h00, 8'h5A, 1'b0},  // R5 invert
    {1'b0, 3'd2, 8'h00, 8'hB4, 1'b0},  // R6 shl, msb 0 lost
    {1'b0, 3'd2, 8'h00, 8'h68, 1'b1},  // R6 shl, msb 1 lost
    {1'b0, 3'd3, 8'h00, 8'h34, 1'b0},  // R7 shr
    {1'b1, 3'd3, 8'h81, 8'h81, 1'b0},  // R3 load over shift code
    {1'b0, 3'd3, 8'h00, 8'h40, 1'b1},  // R7 shr, lsb 1 lost
    {1'b1, 3'd0, 8'h81, 8'h81, 1'b0},  // R3 reload
    {1'b0, 3'd4, 8'h00, 8'h03, 1'b0},  // R8 rotl wraps msb
    {1'b0, 3'd5, 8'h00, 8'h81, 1'b0},  // R9 rotr wraps lsb
    {1'b0, 3'd5, 8'h00, 8'hC0, 1'b0},  // R9 rotr
    {1'b0, 3'd6, 8'h00, 8'h80, 1'b1},  // R10 asl
    {1'b0, 3'd7, 8'h00, 8'hC0, 1'b0},  // R11 asr sign copy
    {1'b0, 3'd7, 8'h00, 8'hE0, 1'b0},  // R11 asr
    {1'b1, 3'd7, 8'h0F, 8'h0F, 1'b0},  // R3 load wins over asr
    {1'b0, 3'd7, 8'h00, 8'h07, 1'b1},  // R11 asr positive, lsb lost
    {1'b0, 3'd6, 8'h00, 8'h0E, 1'b0},  // R10 asl
    {1'b0, 3'd4, 8'h00, 8'h1C, 1'b0}   // R8 rotl
  };

  logic         clk = 1'b0;
  logic         rst, en, load;
  logic [2:0]   sel;
  logic [L-1:0] din;
  logic [L-1:0] q;
  logic         shout;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2 clk = ~clk;

  shreg8m #(.L(L)) u_dut (
    .clk(clk), .rst(rst), .en(en), .load(load),
    .sel(sel), .din(din), .q(q), .shout(shout)
  );

  task automatic check(input string req, input logic [L-1:0] eq, input logic es);
    n_chk++;
    if (q !== eq || shout !== es) begin
      n_bad++;
      $display("FAIL %s: q=%h shout=%b expected q=%h shout=%b", req, q, shout, eq, es);
    end
  endtask

  // drive at falling edge, one rising edge, sample at next falling edge
  task automatic step(input logic r, input logic e, input logic ld,
                      input logic [2:0] s, input logic [L-1:0] d);
    rst = r; en = e; load = ld; sel = s; din = d;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; load = 1'b0; sel = 3'd0; din = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", 8'h00, 1'b0);

    for (int k = 0; k < NV; k++) begin
      step(1'b0, 1'b1, VEC[k][20], VEC[k][19:17], VEC[k][16:9]);
      check($sformatf("vector %0d (R3..R11)", k), VEC[k][8:1], VEC[k][0]);
    end

    // R2: build shout=1, then try load and invert with en low
    step(1'b0, 1'b1, 1'b1, 3'd0, 8'h96);
    check("R3 load 96", 8'h96, 1'b0);
    step(1'b0, 1'b1, 1'b0, 3'd2, 8'h00);
    check("R6 shl 96", 8'h2C, 1'b1);
    step(1'b0, 1'b0, 1'b1, 3'd1, 8'hFF);
    check("R2 load ignored with en low", 8'h2C, 1'b1);
    step(1'b0, 1'b0, 1'b0, 3'd3, 8'h00);
    check("R2 shift ignored with en low", 8'h2C, 1'b1);

    // R1: reset mid-run beats enable and load
    step(1'b1, 1'b1, 1'b1, 3'd1, 8'hFF);
    check("R1 reset over load", 8'h00, 1'b0);

    // R7 top fill and R11 sign copy on all-ones
    step(1'b0, 1'b1, 1'b1, 3'd0, 8'hFF);
    step(1'b0, 1'b1, 1'b0, 3'd3, 8'h00);
    check("R7 shr fills 0 at top", 8'h7F, 1'b1);
    step(1'b0, 1'b1, 1'b1, 3'd0, 8'hFF);
    step(1'b0, 1'b1, 1'b0, 3'd7, 8'h00);
    check("R11 asr keeps ones", 8'hFF, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule